// File: doc/BRIEF.md
# Nibble-Opcode Multi-Cycle Processor

A compact 8-bit processor that runs a two-byte instruction set one phase per clock. It has sixteen general registers, a program counter and an instruction register. One synchronous memory port with 8-bit address and 8-bit data carries both code and data. A read returns its byte one clock after the address is presented.

Every instruction passes through the same fixed sequence of six cycles. Two cycles fetch its two bytes. The following cycles decode it, gather operands, compute and commit, in that order. A phase with no work for a given opcode still takes its cycle, so the run time of a program is exactly six clocks per instruction executed.

A `halted` output tells the environment when the program has stopped. A combinational register-read port lets a testbench inspect any register without disturbing execution.

Top module: `nibble_cpu`

## Requirements
- R1: The first byte of an instruction holds the opcode in bits [7:4] and the register Rn in bits [3:0]. The second byte is the operand: a direct address, an immediate, a signed offset, or Rm in bits [7:4]. The bytes sit at consecutive addresses, with the opcode byte first.
- R2: Opcode 0x0 loads Rn from memory at the direct address.
- R3: Opcode 0x1 writes Rn to memory at the direct address.
- R4: Opcode 0x2 writes Rm to memory at the address held in Rn.
- R5: Opcode 0x3 places the immediate byte in Rn.
- R6: Opcode 0x4 sets Rn to Rn+Rm and opcode 0x5 sets Rn to Rn-Rm. Both are modulo 256.
- R7: Opcode 0x6 jumps only when Rn is zero. The target is the address of the following instruction plus the operand read as a signed byte. When Rn is not zero, execution falls through to the following instruction.
- R8: Every instruction takes exactly six clocks. The PC advances by 2 once per instruction. A store asserts the write strobe for exactly one cycle.
- R9: Opcodes 0x7 to 0xF stop the processor. `halted` then stays high, and no register or memory is written afterwards.
- R10: A synchronous reset clears the PC, the IR and all registers and deasserts `halted`. The first fetch after reset reads address 0.
- R11: `dbgData` shows the register chosen by `dbgSel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 8 | Memory address |
| memRdata | input | 8 | Read data, valid one clock after its address |
| memWe | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| halted | output | 1 | Processor stopped on an undefined opcode |
| dbgSel | input | 4 | Register index for the debug port |
| dbgData | output | 8 | Contents of the selected register |

## Verification
The assertions watch four things on every cycle:
- the write strobe never lasts more than one cycle;
- the PC moves by two at each decode;
- `halted` never drops once it is set;
- a halted core issues no writes.

Only the bench's programs can show that the data moves, the arithmetic results with wrap-around, and the taken and untaken jumps produce the right register and memory contents. The same holds for the exact six-clock timing per instruction, and for reset clearing a core whose registers are already dirty.

// File: rtl/nibble_cpu_pkg.sv
package nibble_cpu_pkg;

  typedef enum logic [2:0] {
    PH_FETCH_A,
    PH_FETCH_B,
    PH_DECODE,
    PH_OPERAND,
    PH_EXECUTE,
    PH_STORE,
    PH_HALT
  } phase_e;

  typedef enum logic [1:0] {
    ASEL_PC,
    ASEL_PC_NEXT,
    ASEL_DIRECT,
    ASEL_INDIRECT
  } addr_sel_e;

  typedef enum logic [3:0] {
    OP_LOAD      = 4'h0,
    OP_STORE     = 4'h1,
    OP_STORE_IND = 4'h2,
    OP_IMM       = 4'h3,
    OP_ADD       = 4'h4,
    OP_SUB       = 4'h5,
    OP_JZ        = 4'h6
  } opcode_e;

  typedef struct packed {
    logic      irHiLoad;
    logic      irLoLoad;
    logic      pcBump;
    logic      operandLatch;
    logic      resultLatch;
    logic      regWrite;
    logic      pcLoad;
    logic      memWrite;
    addr_sel_e addrSel;
    logic      dataFromRm;
  } strobe_t;

endpackage

// File: rtl/nibble_cpu_ctrl.sv
module nibble_cpu_ctrl
  import nibble_cpu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            rnZero,
  output strobe_t         st,
  output logic            halted
);

  localparam logic [OP_W-1:0] LAST_LEGAL = OP_W'(OP_JZ);

  phase_e phase, phaseNext;
  logic   illegal;

  assign illegal = opcode > LAST_LEGAL;
  assign halted  = (phase == PH_HALT);

  always_comb begin
    case (phase)
      PH_FETCH_A: phaseNext = PH_FETCH_B;
      PH_FETCH_B: phaseNext = PH_DECODE;
      PH_DECODE:  phaseNext = PH_OPERAND;
      PH_OPERAND: phaseNext = PH_EXECUTE;
      PH_EXECUTE: phaseNext = PH_STORE;
      PH_STORE:   phaseNext = illegal ? PH_HALT : PH_FETCH_A;
      default:    phaseNext = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH_A;
    else     phase <= phaseNext;
  end

  always_comb begin
    st = '0;
    st.addrSel = ASEL_PC;
    case (phase)
      PH_FETCH_B: begin
        st.addrSel  = ASEL_PC_NEXT;
        st.irHiLoad = 1'b1;
      end
      PH_DECODE: begin
        st.irLoLoad = 1'b1;
        st.pcBump   = 1'b1;
      end
      PH_OPERAND: begin
        st.addrSel      = ASEL_DIRECT;
        st.operandLatch = 1'b1;
      end
      PH_EXECUTE: st.resultLatch = 1'b1;
      PH_STORE: begin
        st.regWrite   = (opcode == OP_W'(OP_LOAD)) || (opcode == OP_W'(OP_IMM)) ||
                        (opcode == OP_W'(OP_ADD))  || (opcode == OP_W'(OP_SUB));
        st.pcLoad     = (opcode == OP_W'(OP_JZ)) && rnZero;
        st.memWrite   = (opcode == OP_W'(OP_STORE)) || (opcode == OP_W'(OP_STORE_IND));
        st.addrSel    = (opcode == OP_W'(OP_STORE_IND)) ? ASEL_INDIRECT : ASEL_DIRECT;
        st.dataFromRm = (opcode == OP_W'(OP_STORE_IND));
      end
      default: ;
    endcase
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    st.memWrite |=> !st.memWrite); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!st.memWrite && !st.regWrite && !st.pcLoad)); // R9

endmodule

// File: rtl/nibble_cpu_dpath.sv
module nibble_cpu_dpath
  import nibble_cpu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 st,
  input  logic [DW-1:0]           memRdata,
  output logic [DW-1:0]           memAddr,
  output logic                    memWe,
  output logic [DW-1:0]           memWdata,
  output logic [DW/2-1:0]         opcode,
  output logic                    rnZero,
  input  logic [$clog2(NREG)-1:0] dbgSel,
  output logic [DW-1:0]           dbgData
);

  localparam int RW   = $clog2(NREG);
  localparam int NW   = DW / 2;
  localparam int IR_W = 2 * DW;

  logic [DW-1:0]   regFile [NREG];
  logic [IR_W-1:0] irReg;
  logic [DW-1:0]   pcReg, opA, opB, result;
  logic [DW-1:0]   operand;
  logic [RW-1:0]   rn, rm;

  assign opcode  = irReg[IR_W-1 -: NW];
  assign rn      = irReg[DW +: RW];
  assign operand = irReg[DW-1:0];
  assign rm      = operand[DW-1 -: RW];
  assign rnZero  = (opA == '0);
  assign dbgData = regFile[dbgSel];

  always_comb begin
    case (st.addrSel)
      ASEL_PC:       memAddr = pcReg;
      ASEL_PC_NEXT:  memAddr = pcReg + DW'(1);
      ASEL_DIRECT:   memAddr = operand;
      default:       memAddr = opA;
    endcase
  end

  assign memWe    = st.memWrite;
  assign memWdata = st.dataFromRm ? opB : opA;

  always_ff @(posedge clk) begin
    if (rst) begin
      irReg  <= '0;
      pcReg  <= '0;
      opA    <= '0;
      opB    <= '0;
      result <= '0;
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else begin
      if (st.irHiLoad) irReg[IR_W-1:DW] <= memRdata;
      if (st.irLoLoad) irReg[DW-1:0]    <= memRdata;
      if (st.pcBump)   pcReg <= pcReg + DW'(2);
      else if (st.pcLoad) pcReg <= result;
      if (st.operandLatch) begin
        opA <= regFile[rn];
        opB <= regFile[rm];
      end
      if (st.resultLatch) begin
        case (opcode)
          NW'(OP_LOAD): result <= memRdata;
          NW'(OP_IMM):  result <= operand;
          NW'(OP_ADD):  result <= opA + opB;
          NW'(OP_SUB):  result <= opA - opB;
          NW'(OP_JZ):   result <= pcReg + operand;
          default:      result <= opA;
        endcase
      end
      if (st.regWrite) regFile[rn] <= result;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    st.pcBump |=> (pcReg == $past(pcReg) + DW'(2))); // R8

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import nibble_cpu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [DW-1:0]           memAddr,
  input  logic [DW-1:0]           memRdata,
  output logic                    memWe,
  output logic [DW-1:0]           memWdata,
  output logic                    halted,
  input  logic [$clog2(NREG)-1:0] dbgSel,
  output logic [DW-1:0]           dbgData
);

  localparam int OP_W = DW / 2;

  strobe_t         st;
  logic [OP_W-1:0] opcode;
  logic            rnZero;

  nibble_cpu_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .rnZero (rnZero),
    .st     (st),
    .halted (halted)
  );

  nibble_cpu_dpath #(.DW(DW), .NREG(NREG)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .opcode   (opcode),
    .rnZero   (rnZero),
    .dbgSel   (dbgSel),
    .dbgData  (dbgData)
  );

endmodule

// File: tb/nibble_cpu_tb.sv
`timescale 1ns/1ps
module nibble_cpu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memAddr, memRdata, memWdata, dbgData;
  logic       memWe, halted;
  logic [3:0] dbgSel = '0;

  logic       clrReq = 1'b0;
  logic       ldEn = 1'b0;
  logic [7:0] ldAddr = '0, ldData = '0;
  logic [7:0] mem [256];
  int         wrCount = 0;
  int         cycCount = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  nibble_cpu dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdata(memRdata),
    .memWe(memWe), .memWdata(memWdata), .halted(halted),
    .dbgSel(dbgSel), .dbgData(dbgData)
  );

  always @(posedge clk) begin
    if (clrReq) for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    else if (ldEn) mem[ldAddr] <= ldData;
    else if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
    if (memWe && !rst) wrCount <= wrCount + 1;
    cycCount <= cycCount + 1;
    if (cycCount > 150000 && !finished) begin
      finished = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycCount, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startLoad();
    @(negedge clk); rst = 1'b1; clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
  endtask

  task automatic put(input int addr, input logic [7:0] b0, input logic [7:0] b1);
    ldEn = 1'b1; ldAddr = 8'(addr); ldData = b0;
    @(negedge clk); ldAddr = 8'(addr + 1); ldData = b1;
    @(negedge clk); ldEn = 1'b0;
  endtask

  task automatic release_();
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input int r, output int v);
    dbgSel = 4'(r); #1; v = int'(dbgData);
  endtask

  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'd3,   8'd4},
    {1'b0, 8'd200, 8'd100},
    {1'b0, 8'd255, 8'd1},
    {1'b1, 8'd10,  8'd3},
    {1'b1, 8'd5,   8'd10},
    {1'b1, 8'd0,   8'd1}
  };

  initial begin
    int cyc, v, w0, exp;

    // Reset state R10
    startLoad();
    put(0, 8'h70, 8'h00);
    release_();
    chk("R10 halted after reset", int'(halted), 0);
    chk("R10 first fetch address", int'(memAddr), 0);

    // Arithmetic table R6 / R3 / R11
    for (int k = 0; k < 6; k++) begin
      logic isSub;
      logic [7:0] a, b;
      {isSub, a, b} = VEC[k];
      exp = isSub ? int'(8'(a - b)) : int'(8'(a + b));
      startLoad();
      put(0, 8'h31, a);
      put(2, 8'h32, b);
      put(4, isSub ? 8'h51 : 8'h41, 8'h20);
      put(6, 8'h11, 8'h80);
      put(8, 8'h70, 8'h00);
      release_();
      run(cyc);
      chk("R6 R3 stored result", int'(mem[8'h80]), exp);
      rd(1, v);
      chk("R11 R6 register result", v, exp);
    end

    // Summing loop R2 R4 R5 R7
    startLoad();
    put(0,  8'h30, 8'h00);
    put(2,  8'h31, 8'h0A);
    put(4,  8'h32, 8'h01);
    put(6,  8'h33, 8'h00);
    put(8,  8'h61, 8'h06);
    put(10, 8'h40, 8'h10);
    put(12, 8'h51, 8'h20);
    put(14, 8'h63, 8'hF8);
    put(16, 8'h10, 8'h90);
    put(18, 8'h34, 8'h91);
    put(20, 8'h24, 8'h00);
    put(22, 8'h05, 8'h90);
    put(24, 8'h70, 8'h00);
    w0 = wrCount;
    release_();
    run(cyc);
    rd(0, v);  chk("R7 R5 sum in R0", v, 55);
    rd(1, v);  chk("R7 loop counter ends at zero", v, 0);
    chk("R3 direct store of sum", int'(mem[8'h90]), 55);
    chk("R4 indirect store of sum", int'(mem[8'h91]), 55);
    rd(5, v);  chk("R2 direct load", v, 55);
    chk("R8 one write per store", wrCount - w0, 2);

    // Jump taken / not taken R7
    startLoad();
    put(0,  8'h31, 8'h01);
    put(2,  8'h61, 8'h02);
    put(4,  8'h32, 8'h11);
    put(6,  8'h33, 8'h22);
    put(8,  8'h64, 8'h02);
    put(10, 8'h35, 8'h55);
    put(12, 8'h36, 8'h66);
    put(14, 8'h70, 8'h00);
    release_();
    run(cyc);
    rd(2, v); chk("R7 untaken falls through", v, 8'h11);
    rd(5, v); chk("R7 taken skips", v, 0);
    rd(6, v); chk("R7 taken lands on target", v, 8'h66);

    // Encoding with high register numbers R1
    startLoad();
    put(0, 8'h3F, 8'h0C);
    put(2, 8'h3E, 8'h03);
    put(4, 8'h5F, 8'hE0);
    put(6, 8'h1F, 8'h81);
    put(8, 8'h70, 8'h00);
    release_();
    run(cyc);
    rd(15, v); chk("R1 Rn=15 Rm=14 subtract", v, 9);
    chk("R1 store from R15", int'(mem[8'h81]), 9);
    rd(0, v);  chk("R1 R0 untouched", v, 0);

    // Timing R8
    startLoad();
    put(0, 8'h31, 8'h05);
    put(2, 8'h70, 8'h00);
    release_();
    run(cyc);
    chk("R8 two instructions take 12 clocks", cyc, 12);

    // Undefined opcodes R9
    startLoad();
    put(0, 8'h80, 8'h00);
    put(2, 8'h31, 8'h07);
    w0 = wrCount;
    release_();
    run(cyc);
    repeat (20) @(negedge clk);
    chk("R9 halted stays high", int'(halted), 1);
    rd(1, v); chk("R9 no execution after halt", v, 0);
    chk("R9 no writes after halt", wrCount - w0, 0);

    startLoad();
    put(0, 8'h33, 8'h05);
    put(2, 8'h7A, 8'h00);
    put(4, 8'h31, 8'h07);
    release_();
    run(cyc);
    rd(3, v); chk("R9 opcode 7 after valid op", v, 5);
    rd(1, v); chk("R9 opcode 7 stops", v, 0);

    // Reset of a dirty core R10
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 halted cleared", int'(halted), 0);
    chk("R10 fetch restarts at 0", int'(memAddr), 0);
    w0 = 0;
    for (int r = 0; r < 16; r++) begin
      rd(r, v);
      if (v != 0) w0++;
    end
    chk("R10 all registers cleared", w0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule